// File: doc/BRIEF.md
# Multi-Cycle Extended Divider

This block is a sequential integer divider for a 16-bit processor datapath. It serves three division operations chosen by a two-bit operation code. The first is a signed 16-by-16 divide of the D operand by X. The second is an unsigned 32-by-16 divide of the concatenation Y:D by X. The third is a signed 32-by-16 divide of Y:D by X. For every operation the caller receives a 16-bit quotient, a 16-bit remainder and four condition flags: negative (N), zero (Z), overflow (V) and carry (C). The caller writes the quotient to X for the 16-bit form and to Y for the 32-bit forms. The remainder always goes to D.

Operands are captured on a start pulse while the block is idle. A restoring shift-subtract loop then retires one quotient bit per clock over 32 steps. Signed forms divide magnitudes and restore the signs in a final fix-up cycle. The result appears with a one-cycle done pulse. A write-enable output qualifies the quotient and remainder. On a zero divisor it stays low, so the surrounding register file keeps its old contents.

Top module: `ext_divider`

## Requirements
- R1: After reset, busy, done, resWe, all four flags, quotient and remainder are all zero.
- R2: A start seen while idle is accepted at that clock edge. busy is high from the next cycle onward. done is high for exactly one cycle, 33 clocks after the accepting edge, and busy is low in that cycle.
- R3: A start pulse while busy has no effect: the running operation finishes with its original operands and timing.
- R4: With opSel = 0, the block divides the signed 16-bit opD by the signed opX and ignores opY. Division truncates toward zero, and the remainder carries the sign of the dividend.
- R5: With opSel = 1, the block divides the unsigned 32-bit value {opY, opD} by the unsigned opX.
- R6: With opSel = 2 or 3, the block divides the signed 32-bit value {opY, opD} by the signed opX. Division truncates toward zero, and the remainder carries the sign of the dividend.
- R7: With opX = 0, the block sets flagC = 1 and drives resWe, flagN, flagZ and flagV to 0. quotient and remainder keep their previous values.
- R8: With a nonzero divisor, flagC = 0 and resWe = 1. flagZ is set when the true quotient is zero. flagN equals bit 15 of the delivered quotient.
- R9: For opSel = 1, flagV is set when the true quotient is 65536 or more. The delivered quotient is then the low 16 bits of the true quotient.
- R10: For opSel = 2 or 3, flagV is set when the true quotient lies outside -32768..32767. The delivered quotient is then the low 16 bits of the two's complement true quotient.
- R11: For opSel = 0, flagV is set only when the true quotient is +32768 (-32768 divided by -1). The delivered quotient is then 0x8000.
- R12: A start in the same cycle as done is accepted. The finished result is still delivered in that cycle, and the new operation completes 33 clocks later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | Request to begin a divide |
| opSel | input | 2 | Operation: 0 signed 16/16, 1 unsigned 32/16, 2 and 3 signed 32/16 |
| opY | input | 16 | Upper dividend half (32-bit forms) |
| opD | input | 16 | Dividend (16-bit form) or lower dividend half |
| opX | input | 16 | Divisor |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| quotient | output | 16 | Delivered quotient |
| remainder | output | 16 | Delivered remainder |
| resWe | output | 1 | Quotient and remainder valid for write-back |
| flagN | output | 1 | Negative flag |
| flagZ | output | 1 | Zero flag |
| flagV | output | 1 | Overflow flag |
| flagC | output | 1 | Divide-by-zero carry flag |

## Verification
Completion and acceptance of a new request can coincide. This happens when a start is presented in the very cycle that done is high, because busy has already dropped there. The bench provokes this case by launching a second divide exactly on the done cycle of a first. It then judges that the first result was presented intact in that cycle and that the second one arrives a full 33 clocks later with its own values. A start pulse given mid-run is also shown to leave the running operation's result and latency untouched.

// File: rtl/ext_divider_pkg.sv
package ext_divider_pkg;
  typedef enum logic [1:0] {
    OP_SDIV16  = 2'd0,
    OP_UDIV32  = 2'd1,
    OP_SDIV32  = 2'd2,
    OP_SDIV32B = 2'd3
  } div_op_e;

  typedef struct packed {
    logic load;
    logic step;
    logic finish;
  } div_ctl_t;
endpackage

// File: rtl/ext_divider_ctrl.sv
module ext_divider_ctrl
  import ext_divider_pkg::*;
#(
  parameter int HALF_W = 16
) (
  input  logic     clk,
  input  logic     rstN,
  input  logic     start,
  output div_ctl_t ctl,
  output logic     busy,
  output logic     done
);
  localparam int ITER  = 2 * HALF_W;
  localparam int CNT_W = $clog2(ITER + 1);

  logic [CNT_W-1:0] cnt;
  logic             lastStep;

  assign lastStep   = (cnt == CNT_W'(ITER));
  assign ctl.load   = start & ~busy;
  assign ctl.step   = busy & ~lastStep;
  assign ctl.finish = busy & lastStep;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      busy <= 1'b0;
      done <= 1'b0;
      cnt  <= '0;
    end else begin
      done <= 1'b0;
      if (ctl.load) begin
        busy <= 1'b1;
        cnt  <= '0;
      end else if (ctl.finish) begin
        busy <= 1'b0;
        done <= 1'b1;
      end else if (ctl.step) begin
        cnt <= cnt + 1'b1;
      end
    end
  end

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);  // R2
  AST_BUSY_OFF_AT_DONE: assert property (@(posedge clk) disable iff (!rstN)
    done |-> !busy);  // R2
  AST_RUN_CONTINUES: assert property (@(posedge clk) disable iff (!rstN)
    (busy && !lastStep) |=> busy);  // R3
endmodule

// File: rtl/ext_divider_dp.sv
module ext_divider_dp
  import ext_divider_pkg::*;
#(
  parameter int HALF_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  div_ctl_t          ctl,
  input  logic [1:0]        opSel,
  input  logic [HALF_W-1:0] opY,
  input  logic [HALF_W-1:0] opD,
  input  logic [HALF_W-1:0] opX,
  output logic [HALF_W-1:0] quotient,
  output logic [HALF_W-1:0] remainder,
  output logic              resWe,
  output logic              flagN,
  output logic              flagZ,
  output logic              flagV,
  output logic              flagC
);
  localparam int FULL_W = 2 * HALF_W;
  localparam logic [FULL_W-1:0] POS_LIM = {{(HALF_W+1){1'b0}}, {(HALF_W-1){1'b1}}};
  localparam logic [FULL_W-1:0] NEG_LIM = POS_LIM + 1'b1;

  // operand capture
  logic              signedIn, wideIn, dndNegIn, dvsNegIn;
  logic [FULL_W-1:0] dndIn, dndMagIn;
  logic [HALF_W-1:0] dvsMagIn;

  assign signedIn = (opSel != OP_UDIV32);
  assign wideIn   = (opSel != OP_SDIV16);
  assign dndIn    = wideIn ? {opY, opD} : {{HALF_W{opD[HALF_W-1]}}, opD};
  assign dndNegIn = signedIn & dndIn[FULL_W-1];
  assign dvsNegIn = signedIn & opX[HALF_W-1];
  assign dndMagIn = dndNegIn ? (~dndIn + 1'b1) : dndIn;
  assign dvsMagIn = dvsNegIn ? (~opX + 1'b1) : opX;

  // working state
  logic [FULL_W-1:0] quoR;
  logic [HALF_W-1:0] remR, dvsR;
  logic              dndNegR, dvsNegR, signedR, zeroR;

  // one restoring step
  logic [HALF_W:0] shifted, diff;
  logic            fits;

  assign shifted = {remR, quoR[FULL_W-1]};
  assign diff    = shifted - {1'b0, dvsR};
  assign fits    = (shifted >= {1'b0, dvsR});

  // sign fix-up and flags
  logic              qNeg, ovf;
  logic [HALF_W-1:0] qLow, rOut;

  assign qNeg = signedR & (dndNegR ^ dvsNegR);
  assign qLow = qNeg ? (~quoR[HALF_W-1:0] + 1'b1) : quoR[HALF_W-1:0];
  assign rOut = dndNegR ? (~remR + 1'b1) : remR;
  assign ovf  = signedR ? (qNeg ? (quoR > NEG_LIM) : (quoR > POS_LIM))
                        : (|quoR[FULL_W-1:HALF_W]);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      quoR      <= '0;
      remR      <= '0;
      dvsR      <= '0;
      dndNegR   <= 1'b0;
      dvsNegR   <= 1'b0;
      signedR   <= 1'b0;
      zeroR     <= 1'b0;
      quotient  <= '0;
      remainder <= '0;
      resWe     <= 1'b0;
      flagN     <= 1'b0;
      flagZ     <= 1'b0;
      flagV     <= 1'b0;
      flagC     <= 1'b0;
    end else if (ctl.load) begin
      quoR    <= dndMagIn;
      remR    <= '0;
      dvsR    <= dvsMagIn;
      dndNegR <= dndNegIn;
      dvsNegR <= dvsNegIn;
      signedR <= signedIn;
      zeroR   <= (opX == '0);
    end else if (ctl.step) begin
      remR <= fits ? diff[HALF_W-1:0] : shifted[HALF_W-1:0];
      quoR <= {quoR[FULL_W-2:0], fits};
    end else if (ctl.finish) begin
      flagC <= zeroR;
      resWe <= ~zeroR;
      if (zeroR) begin
        flagN <= 1'b0;
        flagZ <= 1'b0;
        flagV <= 1'b0;
      end else begin
        quotient  <= qLow;
        remainder <= rOut;
        flagN     <= qLow[HALF_W-1];
        flagZ     <= (quoR == '0);
        flagV     <= ovf;
      end
    end
  end

  AST_OPERANDS_HELD: assert property (@(posedge clk) disable iff (!rstN)
    ctl.step |=> ($stable(dvsR) && $stable(zeroR) && $stable(signedR)));  // R3
  AST_REM_BELOW_DIVISOR: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.step && !zeroR) |=> (remR < dvsR));  // R5
endmodule

// File: rtl/ext_divider.sv
module ext_divider
  import ext_divider_pkg::*;
#(
  parameter int HALF_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  input  logic [1:0]        opSel,
  input  logic [HALF_W-1:0] opY,
  input  logic [HALF_W-1:0] opD,
  input  logic [HALF_W-1:0] opX,
  output logic              busy,
  output logic              done,
  output logic [HALF_W-1:0] quotient,
  output logic [HALF_W-1:0] remainder,
  output logic              resWe,
  output logic              flagN,
  output logic              flagZ,
  output logic              flagV,
  output logic              flagC
);
  div_ctl_t ctl;

  ext_divider_ctrl #(.HALF_W(HALF_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .start(start), .ctl(ctl), .busy(busy), .done(done)
  );

  ext_divider_dp #(.HALF_W(HALF_W)) u_dp (
    .clk(clk), .rstN(rstN), .ctl(ctl), .opSel(opSel), .opY(opY), .opD(opD), .opX(opX),
    .quotient(quotient), .remainder(remainder), .resWe(resWe),
    .flagN(flagN), .flagZ(flagZ), .flagV(flagV), .flagC(flagC)
  );

  AST_CARRY_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rstN)
    done |-> (flagC ^ resWe));  // R7
endmodule

// File: tb/ext_divider_tb.sv
`timescale 1ns/1ps
module ext_divider_tb;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        start = 1'b0;
  logic [1:0]  opSel = 2'd0;
  logic [15:0] opY = '0, opD = '0, opX = '0;
  logic        busy, done, resWe, flagN, flagZ, flagV, flagC;
  logic [15:0] quotient, remainder;

  int checkCnt = 0;
  int failCnt  = 0;

  always #2 clk = ~clk;

  ext_divider u_dut (
    .clk(clk), .rstN(rstN), .start(start), .opSel(opSel), .opY(opY), .opD(opD), .opX(opX),
    .busy(busy), .done(done), .quotient(quotient), .remainder(remainder), .resWe(resWe),
    .flagN(flagN), .flagZ(flagZ), .flagV(flagV), .flagC(flagC)
  );

  typedef struct packed {
    logic [1:0]  op;
    logic [15:0] y, d, x, q, r;
    logic        n, z, v, c, we;
    logic [3:0]  req;
  } vec_t;

  localparam int NVEC = 19;
  localparam vec_t VECS [NVEC] = '{
    '{2'd0, 16'hABCD, 16'h0064, 16'h0007, 16'h000E, 16'h0002, 1'b0,1'b0,1'b0,1'b0,1'b1, 4'd4},  // R4 opY ignored
    '{2'd0, 16'h0000, 16'hFF9C, 16'h0007, 16'hFFF2, 16'hFFFE, 1'b1,1'b0,1'b0,1'b0,1'b1, 4'd4},  // R4
    '{2'd0, 16'h0000, 16'h0064, 16'hFFF9, 16'hFFF2, 16'h0002, 1'b1,1'b0,1'b0,1'b0,1'b1, 4'd4},  // R4
    '{2'd0, 16'h0000, 16'hFF9C, 16'hFFF9, 16'h000E, 16'hFFFE, 1'b0,1'b0,1'b0,1'b0,1'b1, 4'd4},  // R4
    '{2'd0, 16'h0000, 16'h8000, 16'hFFFF, 16'h8000, 16'h0000, 1'b1,1'b0,1'b1,1'b0,1'b1, 4'd11}, // R11
    '{2'd0, 16'h0000, 16'h0003, 16'h0005, 16'h0000, 16'h0003, 1'b0,1'b1,1'b0,1'b0,1'b1, 4'd8},  // R8
    '{2'd1, 16'h0001, 16'h0000, 16'h0003, 16'h5555, 16'h0001, 1'b0,1'b0,1'b0,1'b0,1'b1, 4'd5},  // R5
    '{2'd1, 16'h0002, 16'h0000, 16'h0002, 16'h0000, 16'h0000, 1'b0,1'b0,1'b1,1'b0,1'b1, 4'd9},  // R9
    '{2'd1, 16'hFFFF, 16'hFFFF, 16'hFFFF, 16'h0001, 16'h0000, 1'b0,1'b0,1'b1,1'b0,1'b1, 4'd9},  // R9
    '{2'd1, 16'h0000, 16'h8000, 16'h0001, 16'h8000, 16'h0000, 1'b1,1'b0,1'b0,1'b0,1'b1, 4'd8},  // R8
    '{2'd2, 16'hFFFF, 16'hFF9C, 16'h0007, 16'hFFF2, 16'hFFFE, 1'b1,1'b0,1'b0,1'b0,1'b1, 4'd6},  // R6
    '{2'd2, 16'hFFFF, 16'h8000, 16'h0001, 16'h8000, 16'h0000, 1'b1,1'b0,1'b0,1'b0,1'b1, 4'd10}, // R10
    '{2'd2, 16'h0000, 16'h8000, 16'h0001, 16'h8000, 16'h0000, 1'b1,1'b0,1'b1,1'b0,1'b1, 4'd10}, // R10
    '{2'd2, 16'hFFFF, 16'h7FFF, 16'h0001, 16'h7FFF, 16'h0000, 1'b0,1'b0,1'b1,1'b0,1'b1, 4'd10}, // R10
    '{2'd2, 16'h8000, 16'h0000, 16'hFFFF, 16'h0000, 16'h0000, 1'b0,1'b0,1'b1,1'b0,1'b1, 4'd10}, // R10
    '{2'd2, 16'h0001, 16'h0000, 16'hFFFD, 16'hAAAB, 16'h0001, 1'b1,1'b0,1'b0,1'b0,1'b1, 4'd6},  // R6
    '{2'd0, 16'h0000, 16'h0005, 16'h0000, 16'hAAAB, 16'h0001, 1'b0,1'b0,1'b0,1'b1,1'b0, 4'd7},  // R7 hold
    '{2'd1, 16'h1234, 16'h5678, 16'h0000, 16'hAAAB, 16'h0001, 1'b0,1'b0,1'b0,1'b1,1'b0, 4'd7},  // R7 hold
    '{2'd3, 16'hFFFF, 16'hFF9C, 16'h0007, 16'hFFF2, 16'hFFFE, 1'b1,1'b0,1'b0,1'b0,1'b1, 4'd6}   // R6 code 3
  };

  task automatic check(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    checkCnt++;
    if (!ok) begin
      failCnt++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic launch(input logic [1:0] op, input logic [15:0] y, input logic [15:0] d,
                        input logic [15:0] x);
    start = 1'b1; opSel = op; opY = y; opD = d; opX = x;
    @(negedge clk);
    start = 1'b0;
  endtask

  // Returns latency in clocks after the accepting edge; expects busy high before done.
  task automatic waitDone(output int lat, output bit busyOk);
    lat = 0;
    busyOk = 1'b1;
    while (!done && lat < 100) begin
      if (!busy) busyOk = 1'b0;
      @(negedge clk);
      lat++;
    end
  endtask

  task automatic checkVec(input vec_t v);
    logic [63:0] act, exp;
    act = {quotient, remainder, 11'd0, flagN, flagZ, flagV, flagC, resWe, 16'd0};
    exp = {v.q, v.r, 11'd0, v.n, v.z, v.v, v.c, v.we, 16'd0};
    check(act == exp, $sformatf("R%0d", v.req), "result q|r|nzvc we", act, exp);
  endtask

  initial begin
    int lat;
    bit busyOk;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    check({busy, done, resWe, flagN, flagZ, flagV, flagC, quotient, remainder} == '0,
          "R1", "reset state",
          {busy, done, resWe, flagN, flagZ, flagV, flagC, quotient, remainder}, 64'd0);

    // vector table
    for (int i = 0; i < NVEC; i++) begin
      launch(VECS[i].op, VECS[i].y, VECS[i].d, VECS[i].x);
      waitDone(lat, busyOk);
      check(lat == 33 && busyOk, "R2", "latency/busy", lat, 33);
      checkVec(VECS[i]);
      @(negedge clk);
    end

    // R2 done is a single-cycle pulse
    check(!done && !busy, "R2", "done pulse width", {done, busy}, 0);

    // R3 start while busy is ignored
    launch(2'd0, 16'h0000, 16'h0064, 16'h0007);
    repeat (5) @(negedge clk);
    start = 1'b1; opSel = 2'd1; opY = 16'h0002; opD = 16'h0000; opX = 16'h0002;
    @(negedge clk);
    start = 1'b0;
    waitDone(lat, busyOk);
    check(lat == 27 && busyOk, "R3", "latency unaffected", lat, 27);
    check(quotient == 16'h000E && remainder == 16'h0002 && !flagV, "R3", "first operands kept",
          {quotient, remainder, flagV}, {16'h000E, 16'h0002, 1'b0});

    // R12 new start in the done cycle
    start = 1'b1; opSel = 2'd2; opY = 16'hFFFF; opD = 16'hFF9C; opX = 16'h0007;
    check(quotient == 16'h000E && remainder == 16'h0002 && done, "R12", "first result at done",
          {quotient, remainder, done}, {16'h000E, 16'h0002, 1'b1});
    @(negedge clk);
    start = 1'b0;
    check(busy && !done, "R12", "second accepted", {busy, done}, 2'b10);
    waitDone(lat, busyOk);
    check(lat == 33 && busyOk, "R12", "second latency", lat, 33);
    check(quotient == 16'hFFF2 && remainder == 16'hFFFE && flagN, "R12", "second result",
          {quotient, remainder, flagN}, {16'hFFF2, 16'hFFFE, 1'b1});

    @(negedge clk);
    $display("End of test - %0d assertions evaluated, %0d failures", checkCnt, failCnt);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    failCnt++;
    $display("FAIL R2 watchdog: actual hung expected done");
    $display("End of test - %0d assertions evaluated, %0d failures", checkCnt, failCnt);
    $finish;
  end
endmodule